// File: doc/BRIEF.md
# Timestamp Counter with Selectable Timebase

The block is a free-running timestamp counter for a chip that needs to mark events with a running time value. It runs from a 50 MHz system clock and advances in one of three units: nanoseconds, microseconds or milliseconds. The nanosecond unit cannot resolve single nanoseconds at that clock rate. It therefore adds 20 on every clock, so its value still reads as nanoseconds but moves in 20 ns steps. The microsecond and millisecond units add one on each tick of an internal two-stage prescaler.

Software sees two registers. The setup word at offset 0x600 holds the timebase code in its low byte and a hold bit in bit 8. While the hold bit is set, the counter and the prescaler stay at zero. Counting restarts from zero once a write clears the bit. The count word at offset 0x602 returns the running value and is read-only. A write that carries an unknown timebase code keeps the current timebase. Moving to a different timebase clears the prescaler, so the first tick in the new unit comes one full period after the change.

Top module: `tsc_timestamp`

## Requirements
- R1: During and directly after reset the count is 0, the timebase code is 0 (nanoseconds) and the hold bit is 0.
- R2: Reads at offset 0x600 return the setup word and reads at offset 0x602 return the count zero-extended to 32 bits. Reads at any other offset return 0. Writes to 0x602 or to any other offset outside 0x600 change nothing.
- R3: The setup word reads back the timebase code in bits 7:0 and the hold bit in bit 8. All other bits read 0.
- R4: With code 0 and hold clear, the count grows by NS_STEP (default 20) on every clock.
- R5: With code 1 and hold clear, the count grows by 1 once every US_DIV clocks (default 50, which is 1 µs).
- R6: With code 2 and hold clear, the count grows by 1 once every US_DIV*MS_DIV clocks (default 50*1000, which is 1 ms).
- R7: A setup write with bit 8 = 1 forces the count and the prescaler to 0 from the next clock on and keeps them there. A later write with bit 8 = 0 lets counting resume from 0.
- R8: A setup write whose bits 7:0 exceed 2 leaves the timebase code unchanged. Bit 8 of that same write still updates the hold bit.
- R9: A setup write that changes the timebase code to a different valid value clears the prescaler.
- R10: The count wraps modulo 2^CNT_W (default 32 bits) with no saturation.
- R11: A setup write takes effect at the clock edge it occurs on. During that edge the count still advances under the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read offset (combinational read) |
| rd_data | output | 32 | Read data for rd_addr |

## Verification
The bench builds the block with CNT_W = 12, US_DIV = 5 and MS_DIV = 4 and leaves NS_STEP at 20. The narrow count wraps after about 205 nanosecond-mode clocks, so the wrap is exercised. The short prescaler brings many microsecond and millisecond ticks into a short run. A reference model predicts the value at the read port on every clock. That covers timebase switches made part-way through a prescaler period, a hold bit combined with an invalid code, and the cycle on which each write lands.

// File: rtl/tsc_pkg.sv
// Shared definitions for the timestamp counter.
// Assumes the timebase code occupies the low byte of the setup word.
package tsc_pkg;
    typedef enum logic [1:0] {
        TB_NS = 2'd0,
        TB_US = 2'd1,
        TB_MS = 2'd2
    } tbase_e;

    localparam int SRC_MAX  = 2;   // highest legal timebase code
    localparam int HOLD_BIT = 8;   // position of the hold bit in the setup word
endpackage

// File: rtl/tsc_cfg_reg.sv
// Setup register: holds the timebase code and the hold bit.
// Assumes wr_cfg is a single-cycle strobe already decoded for the setup offset.
module tsc_cfg_reg
    import tsc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cfg,
    input  logic [8:0]   wr_bits,
    output tbase_e       src_q,
    output logic         hold_q,
    output logic         presc_clr
);
    logic code_ok;

    // Decide whether the written code is legal.
    always_comb code_ok = (wr_bits[7:0] <= 8'(SRC_MAX));

    // Pulse that clears the prescaler when the timebase really changes.
    always_comb presc_clr = wr_cfg && code_ok && (tbase_e'(wr_bits[1:0]) != src_q);

    // Store the code (legal writes only) and the hold bit (every write).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= TB_NS;
            hold_q <= 1'b0;
        end else if (wr_cfg) begin
            hold_q <= wr_bits[HOLD_BIT];
            if (code_ok)
                src_q <= tbase_e'(wr_bits[1:0]);
        end
    end

    // R8
    cfg_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && wr_bits[7:0] > 8'(SRC_MAX)) |=> $stable(src_q));

    // R3
    src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> (src_q inside {TB_NS, TB_US, TB_MS}));
endmodule

// File: rtl/tsc_prescaler.sv
// Two-stage prescaler: a microsecond tick every US_DIV clocks and a
// millisecond tick every MS_DIV microsecond ticks.
// Assumes clr is asserted while held and on a timebase change.
module tsc_prescaler #(
    parameter int US_DIV = 50,
    parameter int MS_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic us_tick,
    output logic ms_tick
);
    localparam int US_W = (US_DIV > 1) ? $clog2(US_DIV) : 1;
    localparam int MS_W = (MS_DIV > 1) ? $clog2(MS_DIV) : 1;

    logic [US_W-1:0] us_q;
    logic [MS_W-1:0] ms_q;

    // Terminal-count decode of both stages.
    always_comb begin
        us_tick = (us_q == US_W'(US_DIV - 1));
        ms_tick = us_tick && (ms_q == MS_W'(MS_DIV - 1));
    end

    // Advance the two stages, or clear them.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            us_q <= '0;
            ms_q <= '0;
        end else if (us_tick) begin
            us_q <= '0;
            ms_q <= ms_tick ? '0 : ms_q + 1'b1;
        end else begin
            us_q <= us_q + 1'b1;
        end
    end

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (us_q == '0 && ms_q == '0));

    generate
        if (US_DIV > 1) begin : g_gap
            // R5
            us_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                us_tick |=> !us_tick);
        end
    endgenerate
endmodule

// File: rtl/tsc_count.sv
// Count register: adds NS_STEP per clock, or 1 per prescaler tick,
// depending on the timebase. Wraps modulo 2^CNT_W.
// Assumes the ticks are single-cycle pulses.
module tsc_count
    import tsc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NS_STEP = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  tbase_e           src,
    input  logic             us_tick,
    input  logic             ms_tick,
    output logic [CNT_W-1:0] cnt_q
);
    logic [CNT_W-1:0] step;

    // Select the increment for this clock.
    always_comb begin
        unique case (src)
            TB_NS:   step = CNT_W'(NS_STEP);
            TB_US:   step = us_tick ? CNT_W'(1) : '0;
            TB_MS:   step = ms_tick ? CNT_W'(1) : '0;
            default: step = '0;
        endcase
    end

    // Hold at zero or accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + step;
    end

    // R7
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q == '0));

    // R4
    ns_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && src == TB_NS) |=> (cnt_q == $past(cnt_q) + CNT_W'(NS_STEP)));
endmodule

// File: rtl/tsc_timestamp.sv
// Top of the timestamp counter: decodes the two offsets, joins the
// setup register, prescaler and count register, and forms read data.
// Assumes CNT_W <= 32 and one write per cycle.
module tsc_timestamp
    import tsc_pkg::*;
#(
    parameter int              ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] CFG_OFS = 12'h600,
    parameter logic [ADDR_W-1:0] CNT_OFS = 12'h602,
    parameter int              CNT_W   = 32,
    parameter int              NS_STEP = 20,
    parameter int              US_DIV  = 50,
    parameter int              MS_DIV  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    logic             wr_cfg;
    tbase_e           src_q;
    logic             hold_q;
    logic             presc_clr;
    logic             us_tick;
    logic             ms_tick;
    logic [CNT_W-1:0] cnt_q;
    logic             unused_hi;

    // Write decode for the setup offset.
    always_comb wr_cfg = wr_en && (wr_addr == CFG_OFS);
    // Upper data bits have no storage.
    always_comb unused_hi = ^wr_data[31:9];

    tsc_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cfg    (wr_cfg),
        .wr_bits   (wr_data[8:0]),
        .src_q     (src_q),
        .hold_q    (hold_q),
        .presc_clr (presc_clr)
    );

    tsc_prescaler #(.US_DIV(US_DIV), .MS_DIV(MS_DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hold_q | presc_clr),
        .us_tick (us_tick),
        .ms_tick (ms_tick)
    );

    tsc_count #(.CNT_W(CNT_W), .NS_STEP(NS_STEP)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold_q),
        .src     (src_q),
        .us_tick (us_tick),
        .ms_tick (ms_tick),
        .cnt_q   (cnt_q)
    );

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_addr == CFG_OFS) begin
            rd_data[HOLD_BIT] = hold_q;
            rd_data[1:0]      = src_q;
        end else if (rd_addr == CNT_OFS) begin
            rd_data[CNT_W-1:0] = cnt_q;
        end
    end
endmodule

// File: tb/tsc_timestamp_tb_top.sv
module tsc_timestamp_tb_top;
    localparam int CW = 12, USD = 5, MSD = 4, STEP = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = 12'h602;
    logic [31:0] rd_data;

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    done = 0, wrap_seen = 0;
    int    m_cnt = 0, m_us = 0, m_ms = 0, m_src = 0, m_hold = 0;

    always #5 clk = ~clk;

    tsc_timestamp #(.CNT_W(CW), .NS_STEP(STEP), .US_DIV(USD), .MS_DIV(MSD)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic logic [31:0] exp_read(logic [11:0] a);
        if (a == 12'h600) return 32'((m_hold << 8) | m_src);
        if (a == 12'h602) return 32'(m_cnt);
        return 32'd0;
    endfunction

    // Reference model, updated on every clock from pre-edge state.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_us = 0; m_ms = 0; m_src = 0; m_hold = 0;
        end else begin
            int  n_cnt;
            bit  vwr, chg, legal;
            vwr   = wr_en && wr_addr == 12'h600;
            legal = wr_data[7:0] <= 8'd2;
            chg   = vwr && legal && int'(wr_data[1:0]) != m_src;
            if (m_hold != 0) n_cnt = 0;
            else if (m_src == 0) n_cnt = m_cnt + STEP;
            else if (m_src == 1) n_cnt = m_cnt + ((m_us == USD-1) ? 1 : 0);
            else n_cnt = m_cnt + ((m_us == USD-1 && m_ms == MSD-1) ? 1 : 0);
            if (n_cnt >= (1 << CW)) wrap_seen = 1;
            n_cnt = n_cnt % (1 << CW);
            if (m_hold != 0 || chg) begin
                m_us = 0; m_ms = 0;
            end else if (m_us == USD-1) begin
                m_us = 0;
                m_ms = (m_ms == MSD-1) ? 0 : m_ms + 1;
            end else m_us = m_us + 1;
            m_cnt = n_cnt;
            if (vwr) begin
                m_hold = int'(wr_data[8]);
                if (legal) m_src = int'(wr_data[1:0]);
            end
        end
    end

    // Cycle-by-cycle comparison, just after each edge.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            logic [31:0] e;
            e = exp_read(rd_addr);
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL %s addr=%h actual=%h expected=%h", cur_req, rd_addr, rd_data, e);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic peek_cfg(input logic [31:0] exp, input string req);
        @(negedge clk); rd_addr = 12'h600;
        @(negedge clk); chk(req, rd_data, exp);
        rd_addr = 12'h602;
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk("R1", rd_data, 32'd0);
        rst_n = 1'b1;
        cur_req = "R4";
        repeat (30) @(negedge clk);
        cur_req = "R10";
        repeat (220) @(negedge clk);
        chk("R10", 32'(wrap_seen), 32'd1);
        cur_req = "R11";
        wr(12'h600, 32'h101);
        cur_req = "R7";
        repeat (6) @(negedge clk);
        chk("R7", rd_data, 32'd0);
        cur_req = "R3";
        peek_cfg(32'h101, "R3");
        cur_req = "R5";
        wr(12'h600, 32'h001);
        repeat (40) @(negedge clk);
        cur_req = "R8";
        wr(12'h600, 32'h007);
        peek_cfg(32'h001, "R8");
        cur_req = "R6";
        wr(12'h600, 32'h002);
        repeat (100) @(negedge clk);
        cur_req = "R9";
        wr(12'h600, 32'h001);
        repeat (2) @(negedge clk);
        wr(12'h600, 32'h002);
        repeat (3) @(negedge clk);
        wr(12'h600, 32'h001);
        repeat (12) @(negedge clk);
        cur_req = "R2";
        wr(12'h602, 32'h0);
        wr(12'h123, 32'hFFFF);
        @(negedge clk); rd_addr = 12'h123;
        @(negedge clk); chk("R2", rd_data, 32'd0);
        rd_addr = 12'h602;
        cur_req = "R8";
        wr(12'h600, 32'h1FF);
        peek_cfg(32'h101, "R8");
        cur_req = "R7";
        wr(12'h600, 32'h000);
        repeat (20) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule